// File: doc/BRIEF.md
# Configuration Scan Register Path

This block is a test data register that holds the volatile configuration of a clock device. It sits between TDI and the TDO selector of a test access port. When either the configuration-write or the configuration-read instruction is decoded, the TAP controller's capture, shift and update strobes move data through a 112-stage serial path. When any other instruction is active the path is frozen and does not drive TDO.

The path has two parts. The 96 stages nearest TDO hold configuration bits 0 to 95, with bit 0 in the stage that drives TDO. The 16 stages nearest TDI are reserved and read-only. A write scans bit 0 first, then bits 1 to 95, then 16 fill bits that push the payload into place. An update-DR then copies the 96 configuration stages into the holding register that feeds the chip. A read starts with a capture, which loads the holding register and a fixed reserved constant into the path, so the first bit on TDO is configuration bit 0. Configuration bit 57 is brought out as the PLL disable flag. A restore port lets a nonvolatile-memory controller overwrite the holding register.

Top module: `cfgscan_path`

## Requirements
- R1: After reset, `cfg_word` is all zeros, `tdo_en` is 0 and `tdo` is 0.
- R2: Under configuration-write, shifting 112 bits (configuration bit 0 first, then bits 1 to 95, then 16 fill bits) and then pulsing `update_dr` makes `cfg_word` equal the 96 configuration bits on the cycle after the update.
- R3: `update_dr` changes `cfg_word` only while `sel_write` is high. An update under configuration-read or with no configuration instruction leaves `cfg_word` unchanged.
- R4: Under configuration-read, a capture followed by 96 shifts presents `cfg_word` bits 0, 1, ... 95 on `tdo`, in that order, one bit per shift cycle, with the first bit visible before the first shift edge.
- R5: The reserved stages follow the configuration bits on TDO and always read back the constant 16'hA5C3, least significant bit first, whatever fill bits were written.
- R6: `tdo_en` is high exactly when `shift_dr` is high and a configuration instruction is selected, and `tdo` is 0 whenever `tdo_en` is low. Without a selected configuration instruction the path stages do not change.
- R7: `pll_disable` equals bit 57 of `cfg_word`. A value of 0 means the PLL is enabled.
- R8: A high `tlr` clears `cfg_word` to zero on the next clock edge, and this takes priority over every other load.
- R9: A high `restore_load` loads `restore_word` into `cfg_word` on the next edge, and takes priority over a simultaneous update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| tlr | input | 1 | Test-Logic-Reset state strobe |
| sel_write | input | 1 | Configuration-write instruction decoded |
| sel_read | input | 1 | Configuration-read instruction decoded |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| restore_load | input | 1 | Load holding register from nonvolatile memory |
| restore_word | input | 96 | Configuration restored from nonvolatile memory |
| tdo | output | 1 | Serial data out toward the TDO selector |
| tdo_en | output | 1 | This path is the TDO source |
| cfg_word | output | 96 | Parallel configuration word |
| pll_disable | output | 1 | PLL disable flag (configuration bit 57) |

## Verification
The bench writes a one-hot word for every one of the 96 bit positions. A path that drops the 16 fill shifts, or that reverses the bit order, puts the set bit in the wrong place and also moves the PLL flag away from bit 57. Patterned words are written with different fill values and then read back. A design that copies the fill into the reserved stages, or that starts read-out at the wrong end, returns the wrong leading bit or the wrong reserved constant. Further tests freeze the path partway through a read, issue updates under the wrong instruction, and apply restore together with an update and with TLR. These catch a path that keeps shifting while deselected, a holding register that accepts stray updates, and a load order with the wrong priority.

// File: rtl/cfgscan_pkg.sv
package cfgscan_pkg;
  localparam int CFG_BITS_DFLT = 96;
  localparam int RSV_BITS_DFLT = 16;
  localparam logic [15:0] RSV_VALUE_DFLT = 16'hA5C3;
  localparam int PLL_BIT_DFLT = 57;

  typedef enum logic [1:0] {
    HOLD_KEEP    = 2'd0,
    HOLD_CLEAR   = 2'd1,
    HOLD_RESTORE = 2'd2,
    HOLD_UPDATE  = 2'd3
  } hold_op_e;
endpackage

// File: rtl/cfgscan_rst_sync.sv
module cfgscan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/cfgscan_shift.sv
module cfgscan_shift #(
  parameter int CFG_BITS = 96,
  parameter int RSV_BITS = 16,
  parameter logic [RSV_BITS-1:0] RSV_VALUE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic                shf_en,
  input  logic                tdi,
  input  logic [CFG_BITS-1:0] hold_in,
  output logic [CFG_BITS-1:0] cfg_part,
  output logic                out_bit
);
  localparam int PATH_BITS = CFG_BITS + RSV_BITS;

  logic [PATH_BITS-1:0] path_q;
  logic [PATH_BITS-1:0] path_d;
  logic [PATH_BITS-1:0] load_v;

  assign load_v = {RSV_VALUE, hold_in};

  for (genvar g = 0; g < PATH_BITS; g++) begin : g_stage
    logic feed;
    if (g == PATH_BITS - 1) begin : g_head
      assign feed = tdi;
    end else begin : g_body
      assign feed = path_q[g+1];
    end
    assign path_d[g] = cap_en ? load_v[g] : (shf_en ? feed : path_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) path_q <= '0;
    else        path_q <= path_d;
  end

  assign cfg_part = path_q[CFG_BITS-1:0];
  assign out_bit  = path_q[0];

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !shf_en) |=> $stable(path_q));
  assert_rsv_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (path_q[PATH_BITS-1:CFG_BITS] == RSV_VALUE));
  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en && !cap_en) |=> (path_q[PATH_BITS-1] == $past(tdi)));
endmodule

// File: rtl/cfgscan_hold.sv
module cfgscan_hold
  import cfgscan_pkg::*;
#(
  parameter int CFG_BITS = 96
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tlr,
  input  logic                restore_load,
  input  logic [CFG_BITS-1:0] restore_word,
  input  logic                upd_en,
  input  logic [CFG_BITS-1:0] shift_word,
  output logic [CFG_BITS-1:0] hold_q
);
  hold_op_e            op;
  logic [CFG_BITS-1:0] hold_d;

  always_comb begin
    if (tlr)               op = HOLD_CLEAR;
    else if (restore_load) op = HOLD_RESTORE;
    else if (upd_en)       op = HOLD_UPDATE;
    else                   op = HOLD_KEEP;
  end

  always_comb begin
    unique case (op)
      HOLD_CLEAR:   hold_d = '0;
      HOLD_RESTORE: hold_d = restore_word;
      HOLD_UPDATE:  hold_d = shift_word;
      default:      hold_d = hold_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assert_tlr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (hold_q == '0));
  assert_restore_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_load && !tlr) |=> (hold_q == $past(restore_word)));
endmodule

// File: rtl/cfgscan_path.sv
module cfgscan_path
  import cfgscan_pkg::*;
#(
  parameter int CFG_BITS = CFG_BITS_DFLT,
  parameter int RSV_BITS = RSV_BITS_DFLT,
  parameter logic [RSV_BITS-1:0] RSV_VALUE = RSV_VALUE_DFLT,
  parameter int PLL_BIT = PLL_BIT_DFLT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tlr,
  input  logic                sel_write,
  input  logic                sel_read,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                tdi,
  input  logic                restore_load,
  input  logic [CFG_BITS-1:0] restore_word,
  output logic                tdo,
  output logic                tdo_en,
  output logic [CFG_BITS-1:0] cfg_word,
  output logic                pll_disable
);
  logic                rst_n_sync;
  logic                path_sel;
  logic                cap_en;
  logic                shf_en;
  logic                upd_en;
  logic [CFG_BITS-1:0] cfg_part;
  logic                out_bit;

  assign path_sel = sel_write | sel_read;
  assign cap_en   = capture_dr & path_sel;
  assign shf_en   = shift_dr & path_sel;
  assign upd_en   = update_dr & sel_write;

  cfgscan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cfgscan_shift #(
    .CFG_BITS  (CFG_BITS),
    .RSV_BITS  (RSV_BITS),
    .RSV_VALUE (RSV_VALUE)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .cap_en   (cap_en),
    .shf_en   (shf_en),
    .tdi      (tdi),
    .hold_in  (cfg_word),
    .cfg_part (cfg_part),
    .out_bit  (out_bit)
  );

  cfgscan_hold #(
    .CFG_BITS (CFG_BITS)
  ) u_hold (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .tlr          (tlr),
    .restore_load (restore_load),
    .restore_word (restore_word),
    .upd_en       (upd_en),
    .shift_word   (cfg_part),
    .hold_q       (cfg_word)
  );

  assign tdo_en      = shf_en;
  assign tdo         = shf_en & out_bit;
  assign pll_disable = cfg_word[PLL_BIT];

  assert_update_copy_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (upd_en && !restore_load && !tlr) |=> (cfg_word == $past(cfg_part)));
  assert_no_stray_update_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!sel_write && !restore_load && !tlr) |=> $stable(cfg_word));
  assert_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cap_en |=> (out_bit == $past(cfg_word[0])));
endmodule

// File: tb/cfgscan_path_tb.sv
module cfgscan_path_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CFG = 96;
  localparam int RSV = 16;
  localparam logic [15:0] RSV_CONST = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n, tlr, sel_write, sel_read, capture_dr, shift_dr, update_dr, tdi;
  logic restore_load;
  logic [CFG-1:0] restore_word;
  logic tdo, tdo_en, pll_disable;
  logic [CFG-1:0] cfg_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgscan_path u_dut (
    .clk(clk), .rst_n(rst_n), .tlr(tlr), .sel_write(sel_write), .sel_read(sel_read),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi),
    .restore_load(restore_load), .restore_word(restore_word),
    .tdo(tdo), .tdo_en(tdo_en), .cfg_word(cfg_word), .pll_disable(pll_disable)
  );

  task automatic chk(input string req, input logic [CFG-1:0] act, input logic [CFG-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [CFG-1:0] pat(input int s);
    logic [CFG-1:0] v;
    for (int i = 0; i < CFG; i++) v[i] = (((i * s) + (s * 3) + (i / 3)) % 5) < 2;
    return v;
  endfunction

  task automatic write_cfg(input logic [CFG-1:0] d, input logic [RSV-1:0] fill);
    sel_write = 1'b1;
    capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    shift_dr = 1'b1;
    for (int i = 0; i < CFG + RSV; i++) begin
      tdi = (i < CFG) ? d[i] : fill[i-CFG];
      tick();
    end
    shift_dr = 1'b0; tdi = 1'b0;
    update_dr = 1'b1; tick(); update_dr = 1'b0;
    sel_write = 1'b0;
  endtask

  task automatic read_cfg(output logic [CFG+RSV-1:0] got, output int en_bad);
    en_bad = 0;
    sel_read = 1'b1;
    capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    shift_dr = 1'b1;
    for (int i = 0; i < CFG + RSV; i++) begin
      #1;
      got[i] = tdo;
      if (tdo_en !== 1'b1) en_bad++;
      tick();
    end
    shift_dr = 1'b0;
    sel_read = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CFG+RSV-1:0] got;
    logic [CFG-1:0] ref_w;
    int en_bad;
    rst_n = 1'b0; tlr = 0; sel_write = 0; sel_read = 0; capture_dr = 0;
    shift_dr = 0; update_dr = 0; tdi = 0; restore_load = 0; restore_word = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 cfg_word", cfg_word, '0);
    chk("R1 tdo_en", {95'b0, tdo_en}, '0);
    chk("R1 tdo", {95'b0, tdo}, '0);

    // R2 / R7 one-hot sweep over every bit position
    for (int p = 0; p < CFG; p++) begin
      ref_w = '0; ref_w[p] = 1'b1;
      write_cfg(ref_w, 16'(p * 977));
      chk("R2 one-hot write", cfg_word, ref_w);
      chk("R7 pll flag", {95'b0, pll_disable}, {95'b0, (p == 57)});
    end

    // R2 / R4 / R5 patterned write and read-back with varied fill
    for (int s = 1; s <= 6; s++) begin
      ref_w = pat(s);
      write_cfg(ref_w, (s[0]) ? 16'hFFFF : 16'h0000);
      chk("R2 pattern write", cfg_word, ref_w);
      read_cfg(got, en_bad);
      chk("R4 read order", got[CFG-1:0], ref_w);
      chk("R5 reserved readback", {80'b0, got[CFG+RSV-1:CFG]}, {80'b0, RSV_CONST});
      chk("R6 tdo_en during read", 96'(en_bad), '0);
      chk("R3 read leaves word", cfg_word, ref_w);
    end

    // R3 update under read or no instruction
    ref_w = pat(7);
    write_cfg(ref_w, 16'h1234);
    sel_read = 1'b1; shift_dr = 1'b1; tdi = 1'b1;
    repeat (CFG + RSV) tick();
    shift_dr = 1'b0; update_dr = 1'b1; tick(); update_dr = 1'b0; sel_read = 1'b0;
    tick();
    chk("R3 update under read", cfg_word, ref_w);
    update_dr = 1'b1; tick(); update_dr = 1'b0; tick();
    chk("R3 update unselected", cfg_word, ref_w);

    // R6 frozen path when deselected mid-read
    sel_read = 1'b1; capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    sel_read = 1'b0; shift_dr = 1'b1; tdi = 1'b1;
    for (int k = 0; k < 10; k++) begin
      #1;
      chk("R6 tdo_en deselected", {95'b0, tdo_en}, '0);
      chk("R6 tdo quiet", {95'b0, tdo}, '0);
      tick();
    end
    sel_read = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R6 frozen then resumed", {95'b0, tdo}, {95'b0, ref_w[k]});
      tick();
    end
    shift_dr = 1'b0; sel_read = 1'b0; tdi = 1'b0;

    // R9 restore, and restore beats update
    restore_word = pat(11);
    restore_load = 1'b1; tick(); restore_load = 1'b0;
    chk("R9 restore load", cfg_word, pat(11));
    write_cfg(pat(12), 16'h0);
    chk("R2 after restore", cfg_word, pat(12));
    sel_write = 1'b1; capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    restore_word = pat(13);
    update_dr = 1'b1; restore_load = 1'b1; tick();
    update_dr = 1'b0; restore_load = 1'b0; sel_write = 1'b0;
    chk("R9 restore over update", cfg_word, pat(13));

    // R8 tlr clear with priority over restore
    restore_word = pat(14);
    tlr = 1'b1; restore_load = 1'b1; tick(); tlr = 1'b0; restore_load = 1'b0;
    chk("R8 tlr clear", cfg_word, '0);
    chk("R7 flag after clear", {95'b0, pll_disable}, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule